// File: doc/BRIEF.md
# Return Address Stack

This block keeps the return addresses for subroutine calls and interrupt entries in a chain of shifting registers. No stack pointer exists anywhere. A call or interrupt entry pulses the push strobe with the current program counter. That address goes into the top level, and every level already held moves one place deeper. A return, whether from a subroutine or from an interrupt, pulses the pop strobe. The top level is then handed back as the next program counter, and every deeper level moves one place toward the top.

The chain is reached only through the two strobes and is never part of data memory. When more calls arrive than there are levels, the deepest address falls off the end and the occupancy stays at full. A return on an empty stack reports that no address is available, so the sequencer simply goes on to the next instruction. The caller must never raise push and pop in the same cycle.

Top module: `retaddr_shift_stack`

## Requirements
- R1: A synchronous active-high reset brings `depth_o` to 0 and keeps `ret_valid_o` low.
- R2: A push stores `pc_i` in the top level, and `ret_addr_o` shows it from the cycle after the push edge.
- R3: Pops return the stored addresses newest first, and each pop lowers `depth_o` by one.
- R4: A push while `depth_o` is 6 discards the oldest address and leaves `depth_o` at 6. After the stack is drained, only the six newest addresses have come back.
- R5: A pop while `depth_o` is 0 leaves `depth_o` at 0 and keeps `ret_valid_o` low in that cycle.
- R6: `ret_valid_o` is high only in a cycle where `pop_i` is high and `depth_o` is nonzero. In that cycle `ret_addr_o` carries the address to reload.
- R7: Each pop refills the deepest level with zero. After a full stack has been popped empty, `ret_addr_o` reads 0.
- R8: `depth_o` counts pushes minus pops, saturating at 0 and 6. It never exceeds 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Call or interrupt entry: save `pc_i` |
| pc_i | input | 12 | Program counter value to save |
| pop_i | input | 1 | Return or interrupt return |
| ret_addr_o | output | 12 | Content of the top level (return address) |
| ret_valid_o | output | 1 | The current pop delivers `ret_addr_o` |
| depth_o | output | 3 | Number of valid levels, 0 to 6 |

## Verification
Two things can happen at the same edge. A push into a full chain both shifts the deepest address out and runs into the counter's upper limit. A pop of the last entry both refills the bottom level with zero and brings the counter to its lower limit. The bench causes the first case with eight pushes of distinct addresses. It judges the result by popping everything back: exactly the six newest addresses must return, in reverse order. A further pop must then find zero on `ret_addr_o`, with no valid flag and an occupancy of 0.

// File: rtl/ras_pkg.sv
package ras_pkg;

   // Width needed to count 0..n inclusive.
   function automatic int cnt_width(input int n);
      int w;
      w = 1;
      while ((1 << w) <= n) w++;
      return w;
   endfunction

   // Shift direction applied to the level chain in one cycle.
   typedef enum logic [1:0] {
      SHIFT_HOLD = 2'd0,
      SHIFT_DOWN = 2'd1,   // push: levels move deeper
      SHIFT_UP   = 2'd2    // pop: levels move toward the top
   } shift_e;

endpackage

// File: rtl/ras_occupancy.sv
module ras_occupancy
   import ras_pkg::*;
#(
   parameter int DEPTH = 6,
   localparam int CNT_W = cnt_width(DEPTH)
)(
   input  logic             clk,
   input  logic             rst,
   input  shift_e           op,
   input  logic             push_req,
   input  logic             pop_req,
   output logic [CNT_W-1:0] count,
   output logic             nonempty
);

   localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

   logic [CNT_W-1:0] count_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         count_q <= '0;
      end else begin
         unique case (op)
            SHIFT_DOWN: if (count_q != FULL) count_q <= count_q + 1'b1;
            SHIFT_UP:   count_q <= count_q - 1'b1;
            default:    count_q <= count_q;
         endcase
      end
   end

   assign count    = count_q;
   assign nonempty = (count_q != '0);

   assert_depth_bound_R8: assert property (@(posedge clk) disable iff (rst)
      count_q <= FULL);

   assert_reset_empty_R1: assert property (@(posedge clk)
      rst |=> count_q == '0);

   assert_full_saturates_R4: assert property (@(posedge clk) disable iff (rst)
      (push_req && count_q == FULL) |=> count_q == FULL);

   assert_empty_saturates_R5: assert property (@(posedge clk) disable iff (rst)
      (pop_req && count_q == '0) |=> count_q == '0);

   assert_pop_decrements_R3: assert property (@(posedge clk) disable iff (rst)
      (pop_req && count_q != '0) |=> count_q == $past(count_q) - 1'b1);

endmodule

// File: rtl/ras_level_chain.sv
module ras_level_chain
   import ras_pkg::*;
#(
   parameter int                ADDR_W = 12,
   parameter int                DEPTH  = 6,
   parameter logic [ADDR_W-1:0] FILL   = '0
)(
   input  logic              clk,
   input  logic              rst,
   input  shift_e            op,
   input  logic [ADDR_W-1:0] din,
   output logic [ADDR_W-1:0] top
);

   logic [ADDR_W-1:0] lvl [DEPTH];

   for (genvar i = 0; i < DEPTH; i++) begin : g_lvl
      logic [ADDR_W-1:0] from_above;
      logic [ADDR_W-1:0] from_below;

      if (i == 0) begin : g_first
         assign from_above = din;
      end else begin : g_mid_a
         assign from_above = lvl[i-1];
      end

      if (i == DEPTH - 1) begin : g_last
         assign from_below = FILL;
      end else begin : g_mid_b
         assign from_below = lvl[i+1];
      end

      // Contents need no reset; occupancy alone defines validity.
      always_ff @(posedge clk) begin
         unique case (op)
            SHIFT_DOWN: lvl[i] <= from_above;
            SHIFT_UP:   lvl[i] <= from_below;
            default:    lvl[i] <= lvl[i];
         endcase
      end
   end

   assign top = lvl[0];

   assert_push_loads_top_R2: assert property (@(posedge clk) disable iff (rst)
      op == SHIFT_DOWN |=> top == $past(din));

   if (DEPTH > 1) begin : g_chk_up
      assert_pop_lifts_R3: assert property (@(posedge clk) disable iff (rst)
         op == SHIFT_UP |=> top == $past(lvl[1]));
   end

   assert_pop_fills_bottom_R7: assert property (@(posedge clk) disable iff (rst)
      op == SHIFT_UP |=> lvl[DEPTH-1] == FILL);

endmodule

// File: rtl/retaddr_shift_stack.sv
module retaddr_shift_stack
   import ras_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DEPTH  = 6,
   localparam int CNT_W = cnt_width(DEPTH)
)(
   input  logic              clk,
   input  logic              rst,
   input  logic              push_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              pop_i,
   output logic [ADDR_W-1:0] ret_addr_o,
   output logic              ret_valid_o,
   output logic [CNT_W-1:0]  depth_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("retaddr_shift_stack: DEPTH must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_width
      $error("retaddr_shift_stack: ADDR_W must be at least 1");
   end

   shift_e op;
   logic   nonempty;

   // A pop on an empty stack shifts nothing.
   always_comb begin
      if (push_i)                 op = SHIFT_DOWN;
      else if (pop_i && nonempty) op = SHIFT_UP;
      else                        op = SHIFT_HOLD;
   end

   ras_level_chain #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH),
      .FILL   ('0)
   ) u_chain (
      .clk  (clk),
      .rst  (rst),
      .op   (op),
      .din  (pc_i),
      .top  (ret_addr_o)
   );

   ras_occupancy #(
      .DEPTH (DEPTH)
   ) u_occ (
      .clk      (clk),
      .rst      (rst),
      .op       (op),
      .push_req (push_i),
      .pop_req  (pop_i),
      .count    (depth_o),
      .nonempty (nonempty)
   );

   assign ret_valid_o = pop_i && nonempty;

   assert_valid_needs_pop_R6: assert property (@(posedge clk) disable iff (rst)
      ret_valid_o |-> (pop_i && depth_o != '0));

   assert_push_counts_R8: assert property (@(posedge clk) disable iff (rst)
      (push_i && depth_o != CNT_W'(DEPTH)) |=> depth_o == $past(depth_o) + 1'b1);

endmodule

// File: tb/tb_retaddr_shift_stack.sv
`timescale 1ns/1ps
module tb_retaddr_shift_stack;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        push_i = 1'b0;
   logic        pop_i = 1'b0;
   logic [11:0] pc_i = '0;
   logic [11:0] ret_addr_o;
   logic        ret_valid_o;
   logic [2:0]  depth_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   retaddr_shift_stack dut (
      .clk(clk), .rst(rst), .push_i(push_i), .pc_i(pc_i), .pop_i(pop_i),
      .ret_addr_o(ret_addr_o), .ret_valid_o(ret_valid_o), .depth_o(depth_o)
   );

   task automatic check(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic do_push(input logic [11:0] v);
      @(negedge clk); push_i = 1'b1; pc_i = v;
      @(negedge clk); push_i = 1'b0;
   endtask

   // Pops and checks the same-cycle return port.
   task automatic do_pop(input string req, input bit exp_v, input int exp_a);
      @(negedge clk); pop_i = 1'b1;
      #1;
      check({req, " valid"}, ret_valid_o, exp_v);
      if (exp_v) check({req, " addr"}, ret_addr_o, exp_a);
      @(negedge clk); pop_i = 1'b0;
   endtask

   task automatic apply_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_reset();
      apply_reset();
      check("R1 depth", depth_o, 0);
      check("R1 valid", ret_valid_o, 0);
   endtask

   task automatic t_lifo();
      apply_reset();
      do_push(12'h123);
      check("R2 top", ret_addr_o, 12'h123);
      check("R8 depth", depth_o, 1);
      do_push(12'h456);
      do_push(12'h789);
      check("R2 top", ret_addr_o, 12'h789);
      check("R8 depth", depth_o, 3);
      do_pop("R3", 1, 12'h789);
      check("R3 depth", depth_o, 2);
      do_pop("R3", 1, 12'h456);
      do_push(12'hABC);
      do_pop("R6", 1, 12'hABC);
      do_pop("R3", 1, 12'h123);
      check("R3 depth", depth_o, 0);
   endtask

   task automatic t_overflow();
      apply_reset();
      for (int i = 0; i < 8; i++) do_push(12'h100 + 12'(i));
      check("R4 depth", depth_o, 6);
      for (int i = 7; i >= 2; i--) do_pop("R4", 1, 12'h100 + i);
      check("R4 drained", depth_o, 0);
      do_pop("R4 lost", 0, 0);
   endtask

   task automatic t_underflow();
      apply_reset();
      do_pop("R5", 0, 0);
      check("R5 depth", depth_o, 0);
      do_push(12'h05A);
      check("R5 depth", depth_o, 1);
      do_pop("R5", 1, 12'h05A);
      do_pop("R5", 0, 0);
      check("R5 depth", depth_o, 0);
   endtask

   task automatic t_zero_fill();
      apply_reset();
      for (int i = 0; i < 6; i++) do_push(12'hF00 + 12'(i));
      for (int i = 5; i >= 0; i--) do_pop("R7", 1, 12'hF00 + i);
      check("R7 fill", ret_addr_o, 0);
      @(negedge clk); #1;
      check("R6 idle", ret_valid_o, 0);
   endtask

   initial begin
      #(200000 * 5);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_lifo();
      t_overflow();
      t_underflow();
      t_zero_fill();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule